// File: doc/BRIEF.md
# Quadrature Phase-Accumulator Sine Generator

This block is a direct digital synthesizer. On every enabled clock it adds an unsigned phase step to a phase register that wraps on overflow. The phase value, taken before that addition, addresses two lookup tables. One table holds one full period of cosine and the other holds one full period of sine. The two looked-up samples leave the block as signed fractional words, together with a valid strobe.

The output frequency is `phase_inc / 1024` of the enabled sample rate. Both tables are computed at elaboration from trigonometric functions. The parameters set the phase width, the sample width and the number of fractional bits. The defaults are a 10-bit phase, which gives 1024 entries per table, and 16-bit samples with 15 fractional bits.

Top module: `dds_quad_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears the phase to 0, `cos_out` and `sin_out` to 0 and `out_valid` to 0 after that edge.
- R2: `out_valid` equals the value `en` had at the previous rising edge (one cycle of latency).
- R3: At each rising edge with `en` high, the phase becomes (phase + `phase_inc`) mod 1024. `phase_inc` is a 10-bit unsigned integer.
- R4: At each rising edge with `en` high, `cos_out` takes the cosine table entry of the phase held before that edge. Entry k is round(cos(2πk/1024)·32768), with rounding done as floor(x+0.5).
- R5: At each rising edge with `en` high, `sin_out` takes the sine table entry of the phase held before that edge. Entry k is round(sin(2πk/1024)·32768), with rounding done as floor(x+0.5).
- R6: Samples are two's-complement 16-bit values with 15 fractional bits. A value of +1.0 saturates to 0x7FFF (32767), so `cos_out` is 32767 for phase 0 and `sin_out` is 32767 for phase 256. A value of −1.0 is exact at 0x8000 (−32768), so `cos_out` is −32768 for phase 512.
- R7: When the phase addition passes 1023 it wraps with no saturation. For example, phase 1020 plus step 10 gives phase 6.
- R8: With `phase_inc` = 0, every enabled sample repeats the entry of the current phase.
- R9: With `phase_inc` = 512, successive enabled samples alternate between the phase-0 entries (cos 32767, sin 0) and the phase-512 entries (cos −32768, sin 0).
- R10: At a rising edge with `en` low, the phase, `cos_out` and `sin_out` keep their values and `out_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advances the phase and loads new samples |
| phase_inc | input | 10 | Unsigned phase step added per enabled cycle |
| cos_out | output | 16 | Cosine sample, signed, 15 fractional bits |
| sin_out | output | 16 | Sine sample, signed, 15 fractional bits |
| out_valid | output | 1 | High for one cycle after each enabled edge |

## Verification
The accumulator wrap and the table read happen on the same edge. At that edge the sample must come from the phase before the wrap, and the phase register must take the wrapped sum. The bench sets this up with steps of 1023, 700 and 257, which overflow the accumulator on most cycles. It compares every sample against a reference phase that it keeps itself, so a read of the post-wrap phase, or a sum that saturates instead of wrapping, shows up in the next sample. The fall of `en` is also checked on the cycle right after an enabled edge: the samples must freeze on that edge's values, and the first sample after `en` returns must continue from the phase where it stopped.

// File: rtl/dds_pkg.sv
// Package: shared widths and the elaboration-time table-entry generator.
// Assumes: the table functions are called only with constant arguments.
package dds_pkg;

    localparam int DEF_PHASE_W = 10;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_FRAC_W  = 15;

    localparam real TWO_PI = 6.283185307179586;

    // Returns entry k of a cosine (is_sine=0) or sine (is_sine=1) table.
    // The value is rounded as floor(x+0.5) and clamped to the signed range.
    function automatic int trig_code(int k, int phase_w, int data_w,
                                     int frac_w, bit is_sine);
        real ang;
        real val;
        real scaled;
        real hi;
        real lo;
        ang    = TWO_PI * real'(k) / real'(2 ** phase_w);
        val    = is_sine ? $sin(ang) : $cos(ang);
        scaled = $floor(val * real'(2 ** frac_w) + 0.5);
        hi     = real'((2 ** (data_w - 1)) - 1);
        lo     = -real'(2 ** (data_w - 1));
        if (scaled > hi) scaled = hi;
        if (scaled < lo) scaled = lo;
        return $rtoi(scaled);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
// Module: wrapping phase accumulator.
// Adds an unsigned step to the phase on each enabled clock and wraps
// modulo 2**PHASE_W. Assumes a synchronous active-low reset to phase 0.
module dds_phase_acc #(
    parameter int PHASE_W = dds_pkg::DEF_PHASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase
);

    logic [PHASE_W-1:0] phase_next;

    // Next phase: a modular sum whose carry out is discarded.
    always_comb begin
        phase_next = phase + step;
    end

    // Phase register: clear on reset, advance when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (en) begin
            phase <= phase_next;
        end
    end

endmodule

// File: rtl/dds_trig_rom.sv
// Module: one-period trig table with a registered read port.
// IS_SINE selects sine or cosine contents, which are computed at
// elaboration. The read register loads only when enabled and holds
// otherwise. Assumes the address is a full PHASE_W-bit phase.
module dds_trig_rom #(
    parameter int PHASE_W = dds_pkg::DEF_PHASE_W,
    parameter int DATA_W  = dds_pkg::DEF_DATA_W,
    parameter int FRAC_W  = dds_pkg::DEF_FRAC_W,
    parameter bit IS_SINE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [PHASE_W-1:0]       addr,
    output logic signed [DATA_W-1:0] data
);

    localparam int DEPTH = 2 ** PHASE_W;

    logic signed [DATA_W-1:0] table_w [DEPTH];

    // Table contents: one constant entry per phase, filled at elaboration.
    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        assign table_w[k] = DATA_W'(dds_pkg::trig_code(k, PHASE_W, DATA_W,
                                                       FRAC_W, IS_SINE));
    end

    // Read register: clear on reset, load the addressed entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (en) begin
            data <= table_w[addr];
        end
    end

endmodule

// File: rtl/dds_quad_top.sv
// Module: quadrature sine generator top.
// The accumulator phase from before each enabled update addresses a
// cosine table and a sine table, so both samples appear one cycle after
// the enabled edge. out_valid is en delayed by one cycle.
// Assumes a synchronous active-low reset.
module dds_quad_top #(
    parameter int PHASE_W = dds_pkg::DEF_PHASE_W,
    parameter int DATA_W  = dds_pkg::DEF_DATA_W,
    parameter int FRAC_W  = dds_pkg::DEF_FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [PHASE_W-1:0]       phase_inc,
    output logic signed [DATA_W-1:0] cos_out,
    output logic signed [DATA_W-1:0] sin_out,
    output logic                     out_valid
);

    localparam int NUM_CH = 2;

    logic [PHASE_W-1:0]       phase_q;
    logic signed [DATA_W-1:0] samp [NUM_CH];

    dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .step  (phase_inc),
        .phase (phase_q)
    );

    // Channel 0 is the cosine table and channel 1 the sine table.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dds_trig_rom #(
            .PHASE_W (PHASE_W),
            .DATA_W  (DATA_W),
            .FRAC_W  (FRAC_W),
            .IS_SINE (g == 1)
        ) u_rom (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .addr  (phase_q),
            .data  (samp[g])
        );
    end

    // Output mapping: route the two table reads to the output ports.
    always_comb begin
        cos_out = samp[0];
        sin_out = samp[1];
    end

    // Valid register: follows en with the same latency as the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= en;
        end
    end

endmodule

// File: rtl/dds_quad_chk.sv
// Module: assertion checker for dds_quad_top, attached through bind.
// It observes the ports together with the internal phase register.
module dds_quad_chk #(
    parameter int PHASE_W = 10,
    parameter int DATA_W  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     en,
    input logic [PHASE_W-1:0]       phase_inc,
    input logic [PHASE_W-1:0]       phase,
    input logic signed [DATA_W-1:0] cos_out,
    input logic signed [DATA_W-1:0] sin_out,
    input logic                     out_valid
);

    localparam logic signed [DATA_W-1:0] POS_FULL = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] NEG_FULL = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [PHASE_W-1:0]       HALF_TURN = {1'b1, {(PHASE_W-1){1'b0}}};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (phase == '0 && cos_out == '0 && sin_out == '0 && !out_valid)); // R1

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> out_valid); // R2

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out_valid); // R2

    AST_PHASE_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> phase == PHASE_W'($past(phase) + $past(phase_inc))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(phase) && $stable(cos_out) && $stable(sin_out))); // R10

    AST_COS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase == '0) |=> (cos_out == POS_FULL && sin_out == '0)); // R6

    AST_COS_NEG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase == HALF_TURN) |=> (cos_out == NEG_FULL)); // R6

endmodule

bind dds_quad_top dds_quad_chk #(
    .PHASE_W (PHASE_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .phase_inc (phase_inc),
    .phase     (phase_q),
    .cos_out   (cos_out),
    .sin_out   (sin_out),
    .out_valid (out_valid)
);

// File: tb/tb_dds_quad_top.sv
// Bench: walks a table of step vectors against a bench-side phase model,
// then runs directed reset and corner-case tests.
module tb_dds_quad_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [9:0]        phase_inc = '0;
    logic signed [15:0] cos_out;
    logic signed [15:0] sin_out;
    logic              out_valid;

    int checks = 0;
    int errors = 0;
    int ph = 0;
    int exp_cos = 0;
    int exp_sin = 0;
    bit done = 1'b0;

    localparam int NVEC = 8;
    localparam int VEC_INC [NVEC] = '{1, 3, 1023, 257, 100, 700, 64, 511};
    localparam int VEC_LEN [NVEC] = '{6, 6, 6, 8, 12, 10, 5, 6};

    always #4 clk = ~clk;

    dds_quad_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .phase_inc (phase_inc),
        .cos_out   (cos_out),
        .sin_out   (sin_out),
        .out_valid (out_valid)
    );

    function automatic int ref_val(int k, bit s);
        real a;
        real v;
        real x;
        a = 2.0 * 3.141592653589793 * real'(k) / 1024.0;
        v = s ? $sin(a) : $cos(a);
        x = $floor(v * 32768.0 + 0.5);
        if (x > 32767.0) x = 32767.0;
        if (x < -32768.0) x = -32768.0;
        return $rtoi(x);
    endfunction

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, update the model, check after the rising edge.
    task automatic step(bit e, int inc, string req);
        en = e;
        phase_inc = 10'(inc);
        if (e) begin
            exp_cos = ref_val(ph, 1'b0);
            exp_sin = ref_val(ph, 1'b1);
            ph = (ph + inc) % 1024;
        end
        @(posedge clk);
        #1;
        check_eq({req, " cos"}, int'(cos_out), exp_cos);
        check_eq({req, " sin"}, int'(sin_out), exp_sin);
        check_eq({"R2 valid ", req}, int'(out_valid), int'(e));
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en = 1'b1;
        phase_inc = 10'd77;
        @(posedge clk);
        #1;
        check_eq("R1 cos", int'(cos_out), 0);
        check_eq("R1 sin", int'(sin_out), 0);
        check_eq("R1 valid", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        ph = 0;
        exp_cos = 0;
        exp_sin = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R4 R5 R7: walk the vector table
        for (int v = 0; v < NVEC; v++) begin
            for (int n = 0; n < VEC_LEN[v]; n++) begin
                step(1'b1, VEC_INC[v], "R4/R5/R7 vector");
            end
        end

        // R6: full-scale positive and negative values
        do_reset();
        step(1'b1, 256, "R6 phase0");
        check_eq("R6 cos +1 saturates", int'(cos_out), 32767);
        step(1'b1, 256, "R6 phase256");
        check_eq("R6 sin +1 saturates", int'(sin_out), 32767);
        step(1'b1, 0, "R6 phase512");
        check_eq("R6 cos -1 exact", int'(cos_out), -32768);

        // R8: a zero step repeats the sample
        for (int n = 0; n < 4; n++) begin
            step(1'b1, 0, "R8 zero step");
            check_eq("R8 cos constant", int'(cos_out), -32768);
        end

        // R9: a step of 512 alternates between phase 0 and phase pi
        do_reset();
        for (int n = 0; n < 6; n++) begin
            step(1'b1, 512, "R9 half turn");
            check_eq("R9 cos alternates", int'(cos_out), (n % 2 == 0) ? 32767 : -32768);
            check_eq("R9 sin zero", int'(sin_out), 0);
        end

        // R7: explicit wrap 1020 + 10 -> 6; the sample taken at the wrap edge comes from phase 1020
        do_reset();
        step(1'b1, 1020, "R7 setup");
        step(1'b1, 10, "R7 wrap edge");
        check_eq("R7 pre-wrap sample", int'(cos_out), ref_val(1020, 1'b0));
        step(1'b1, 1, "R7 after wrap");
        check_eq("R7 wrapped phase", int'(sin_out), ref_val(6, 1'b1));

        // R10: en low right after an enabled edge freezes the outputs and the phase
        step(1'b1, 37, "R10 prior");
        for (int n = 0; n < 3; n++) begin
            step(1'b0, 300, "R10 idle");
        end
        step(1'b1, 5, "R10 resume");
        check_eq("R10 resume phase", int'(cos_out), ref_val(44, 1'b0));

        // R1: reset in the middle of a run
        step(1'b1, 123, "R1 pre");
        do_reset();
        step(1'b1, 9, "R1 restart");
        check_eq("R1 restart from phase 0", int'(cos_out), 32767);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule